// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits behind a CAN receiver that has already checked a frame and hands it over as a single-cycle pulse. The pulse carries the identifier, the standard or extended flag, the remote flag, the length code and eight data bytes. The block keeps a bank of receive mailboxes. Each mailbox has a mode, an acceptance identifier and an acceptance mask. Each arriving frame is written into the lowest-numbered mailbox that is enabled, empty and whose filter matches the frame.

Every mailbox has a full flag. The vector of full flags is also the interrupt output. Software reads a captured frame through a small register port. It then frees any group of mailboxes with one write-one-to-clear re-arm word. Reading a mailbox does not free it. A mailbox in overwrite mode still takes a matching frame when it is full and no free mailbox wants the frame. It replaces the stored frame and raises a missed-message flag.

Top module: `can_rx_mailboxes`

## Requirements
- R1: After reset every mailbox is disabled (mode 0), empty and without a missed flag, so `irq` and the full vector read 0.
- R2: Mode codes 0 and 3 are disabled. A disabled mailbox never takes a frame. A frame that no mailbox can take is dropped, and every stored field stays as it was.
- R3: A frame goes into the lowest-numbered mailbox that is in mode 1 or mode 2, is empty and matches. A frame fills at most one mailbox.
- R4: The frame key is {ext, id} for extended frames and {0, id[10:0], 18 zeros} for standard frames. Bit 29 is the extended flag. A standard identifier sits at bits 28:18. A mailbox matches when ((key ^ acc) & mask) is zero over bits 28:0 and bit 29 of the key equals bit 29 of the acceptance identifier.
- R5: Mailbox field 3 returns the received key. Field 4 is the status word: length in bits 19:16, remote flag in bit 20, full in bit 23, missed in bit 24. Fields 5 and 6 return data bytes 3..0 and 7..4.
- R6: Bit i of `irq` and of the global full word (global offset 0) is the full flag of mailbox i. It rises at the first clock edge after the accepting `rx_valid` cycle and never rises without a frame.
- R7: Writing a mask to the global re-arm word (global offset 1) clears the full and missed flags of every mailbox whose bit is 1. Mailboxes whose bit is 0 keep their state.
- R8: When no empty match exists, the lowest full, matching mailbox in mode 2 takes the frame: its data, key and status are replaced and its missed flag is set. A full mailbox in mode 1 is never overwritten.
- R9: Register reads and configuration writes never change the full vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle pulse: a completed frame is present |
| rx_ext | input | 1 | Frame uses an extended identifier |
| rx_rtr | input | 1 | Frame is a remote request |
| rx_id | input | 29 | Identifier (standard identifiers in bits 10:0) |
| rx_len | input | 4 | Length code |
| rx_data | input | 64 | Data, byte 0 in bits 7:0 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (7) | Bit 6 selects global space; bits 5:3 mailbox; bits 2:0 field |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | NUM_MB (8) | Full flag per mailbox |

Per-mailbox fields: 0 mode in bits 1:0, 1 acceptance identifier (bits 29:0), 2 mask (bits 28:0), 3 received key, 4 status, 5 low data, 6 high data.

## Verification
A corrupted full flag shows on `irq` at the edge after the offending cycle. A wrong filter result or wrong priority choice shows one edge after the frame pulse, as a bit set in the wrong position or no bit set at all. Stored content that is mis-steered appears only on readback of fields 3 to 6. For this reason the bench reads every filled mailbox, and reads it again after frames that must be dropped. A missed flag that is stuck or lost is exposed through status bit 24 after an overwrite and after a re-arm.

// File: rtl/can_mbx_pkg.sv
`timescale 1ns/1ps
package can_mbx_pkg;

    typedef enum logic [1:0] {
        MB_OFF    = 2'd0,
        MB_RX     = 2'd1,
        MB_RX_OVW = 2'd2,
        MB_RSVD   = 2'd3
    } mb_mode_e;

    localparam int KEY_W     = 30;
    localparam int EXT_BIT   = 29;
    localparam int STD_LSB   = 18;

    localparam logic [2:0] FLD_CFG  = 3'd0;
    localparam logic [2:0] FLD_ACC  = 3'd1;
    localparam logic [2:0] FLD_MSK  = 3'd2;
    localparam logic [2:0] FLD_RXID = 3'd3;
    localparam logic [2:0] FLD_STAT = 3'd4;
    localparam logic [2:0] FLD_DLO  = 3'd5;
    localparam logic [2:0] FLD_DHI  = 3'd6;

    localparam logic [2:0] GLB_FULL  = 3'd0;
    localparam logic [2:0] GLB_REARM = 3'd1;

    localparam int ST_LEN_LSB = 16;
    localparam int ST_RTR     = 20;
    localparam int ST_FULL    = 23;
    localparam int ST_MISS    = 24;

    typedef struct packed {
        mb_mode_e          mode;
        logic [KEY_W-1:0]  acc;
        logic [KEY_W-2:0]  msk;
    } mb_cfg_t;

    typedef struct packed {
        logic [KEY_W-1:0]  rid;
        logic              rtr;
        logic [3:0]        len;
        logic [63:0]       data;
    } mb_slot_t;

    function automatic logic [KEY_W-1:0] make_key(input logic ext, input logic [28:0] id);
        if (ext) return {1'b1, id};
        return {1'b0, id[10:0], {STD_LSB{1'b0}}};
    endfunction

    function automatic logic key_match(input logic [KEY_W-1:0] key, input mb_cfg_t cfg);
        return (((key[KEY_W-2:0] ^ cfg.acc[KEY_W-2:0]) & cfg.msk) == '0)
               && (key[EXT_BIT] == cfg.acc[EXT_BIT]);
    endfunction

endpackage

// File: rtl/can_mbx_accept.sv
`timescale 1ns/1ps
module can_mbx_accept
    import can_mbx_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic [KEY_W-1:0] key,
    input  mb_cfg_t          cfg [NUM_MB],
    input  logic [NUM_MB-1:0] full,
    output logic [NUM_MB-1:0] free_hit,
    output logic [NUM_MB-1:0] ovw_hit
);
    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic hit;
        logic on;
        assign hit         = key_match(key, cfg[i]);
        assign on          = (cfg[i].mode == MB_RX) || (cfg[i].mode == MB_RX_OVW);
        assign free_hit[i] = hit && on && !full[i];
        assign ovw_hit[i]  = hit && full[i] && (cfg[i].mode == MB_RX_OVW);
    end
endmodule

// File: rtl/can_mbx_first.sv
`timescale 1ns/1ps
module can_mbx_first #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
    assign any = |req;
endmodule

// File: rtl/can_rx_mailboxes.sv
`timescale 1ns/1ps
module can_rx_mailboxes
    import can_mbx_pkg::*;
#(
    parameter  int NUM_MB = 8,
    localparam int MB_W   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int ADDR_W = MB_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_ext,
    input  logic              rx_rtr,
    input  logic [28:0]       rx_id,
    input  logic [3:0]        rx_len,
    input  logic [63:0]       rx_data,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_MB-1:0] irq
);
    mb_cfg_t           cfg  [NUM_MB];
    mb_slot_t          slot [NUM_MB];
    logic [NUM_MB-1:0] full;
    logic [NUM_MB-1:0] miss;

    logic [KEY_W-1:0]  key;
    logic [NUM_MB-1:0] free_hit, ovw_hit, free_g, ovw_g;
    logic              free_any, ovw_any;
    logic [NUM_MB-1:0] store_sel, miss_set, rearm;

    logic              is_glb;
    logic [MB_W-1:0]   mb_idx;
    logic [2:0]        fld;
    logic              unused_bits;

    assign key    = make_key(rx_ext, rx_id);
    assign is_glb = bus_addr[ADDR_W-1];
    assign mb_idx = bus_addr[3 +: MB_W];
    assign fld    = bus_addr[2:0];
    assign unused_bits = ^bus_wdata[31:30] ^ ovw_any;

    can_mbx_accept #(.NUM_MB(NUM_MB)) u_accept (
        .key(key), .cfg(cfg), .full(full),
        .free_hit(free_hit), .ovw_hit(ovw_hit)
    );

    can_mbx_first #(.N(NUM_MB)) u_pick_free (
        .req(free_hit), .grant(free_g), .any(free_any)
    );

    can_mbx_first #(.N(NUM_MB)) u_pick_ovw (
        .req(ovw_hit), .grant(ovw_g), .any(ovw_any)
    );

    always_comb begin
        store_sel = '0;
        miss_set  = '0;
        if (rx_valid) begin
            if (free_any) begin
                store_sel = free_g;
            end else begin
                store_sel = ovw_g;
                miss_set  = ovw_g;
            end
        end
        rearm = (bus_we && is_glb && fld == GLB_REARM) ? bus_wdata[NUM_MB-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= '0;
            miss <= '0;
            for (int i = 0; i < NUM_MB; i++) begin
                cfg[i]  <= '{mode: MB_OFF, acc: '0, msk: '0};
                slot[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_MB; i++) begin
                if (bus_we && !is_glb && mb_idx == MB_W'(i)) begin
                    case (fld)
                        FLD_CFG: cfg[i].mode <= mb_mode_e'(bus_wdata[1:0]);
                        FLD_ACC: cfg[i].acc  <= bus_wdata[KEY_W-1:0];
                        FLD_MSK: cfg[i].msk  <= bus_wdata[KEY_W-2:0];
                        default: ;
                    endcase
                end
                if (rearm[i]) begin
                    full[i] <= 1'b0;
                    miss[i] <= 1'b0;
                end
                if (store_sel[i]) begin
                    slot[i] <= '{rid: key, rtr: rx_rtr, len: rx_len, data: rx_data};
                    full[i] <= 1'b1;
                end
                if (miss_set[i]) miss[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (is_glb) begin
            if (fld == GLB_FULL) bus_rdata[NUM_MB-1:0] = full;
        end else if (int'(mb_idx) < NUM_MB) begin
            case (fld)
                FLD_CFG:  bus_rdata[1:0]       = cfg[mb_idx].mode;
                FLD_ACC:  bus_rdata[KEY_W-1:0] = cfg[mb_idx].acc;
                FLD_MSK:  bus_rdata[KEY_W-2:0] = cfg[mb_idx].msk;
                FLD_RXID: bus_rdata[KEY_W-1:0] = slot[mb_idx].rid;
                FLD_STAT: begin
                    bus_rdata[ST_LEN_LSB +: 4] = slot[mb_idx].len;
                    bus_rdata[ST_RTR]          = slot[mb_idx].rtr;
                    bus_rdata[ST_FULL]         = full[mb_idx];
                    bus_rdata[ST_MISS]         = miss[mb_idx];
                end
                FLD_DLO:  bus_rdata = slot[mb_idx].data[31:0];
                FLD_DHI:  bus_rdata = slot[mb_idx].data[63:32];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = full;

endmodule

// File: rtl/can_rx_mailboxes_chk.sv
`timescale 1ns/1ps
module can_rx_mailboxes_chk #(
    parameter int NUM_MB = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rearm_wr,
    input logic [NUM_MB-1:0] rearm_bits,
    input logic [NUM_MB-1:0] irq
);
    // R1: mailboxes come out of reset empty
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0));

    // R3: one frame fills at most one mailbox
    p_single_fill_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> $onehot0(irq & ~$past(irq)));

    // R6: no full flag rises without a frame
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> ((irq & ~$past(irq)) == '0));

    // R7: re-armed mailboxes are empty afterwards
    p_rearm_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rearm_wr && !rx_valid) |=> ((irq & $past(rearm_bits)) == '0));

    // R9: without a frame or re-arm the full vector holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !rearm_wr) |=> (irq == $past(irq)));
endmodule

bind can_rx_mailboxes can_rx_mailboxes_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk(clk),
    .rst(rst),
    .rx_valid(rx_valid),
    .rearm_wr(bus_we && bus_addr[ADDR_W-1] && (bus_addr[2:0] == 3'd1)),
    .rearm_bits(bus_wdata[NUM_MB-1:0]),
    .irq(irq)
);

// File: tb/can_rx_mailboxes_tb.sv
`timescale 1ns/1ps
module can_rx_mailboxes_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_ext = 1'b0, rx_rtr = 1'b0;
    logic [28:0] rx_id = '0;
    logic [3:0]  rx_len = '0;
    logic [63:0] rx_data = '0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_rx_mailboxes u_dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_ext(rx_ext), .rx_rtr(rx_rtr),
        .rx_id(rx_id), .rx_len(rx_len), .rx_data(rx_data),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [6:0] a_mb(input int mb, input int f);
        return {1'b0, 3'(mb), 3'(f)};
    endfunction
    function automatic logic [6:0] a_glb(input int f);
        return {1'b1, 3'b000, 3'(f)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send(input logic ext, input logic rtr, input logic [28:0] id,
                        input logic [3:0] len, input logic [63:0] data);
        @(negedge clk);
        rx_valid = 1'b1; rx_ext = ext; rx_rtr = rtr; rx_id = id; rx_len = len; rx_data = data;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  exp_irq;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        rd(a_glb(0), r); chk("R1 full word", r, 0);
        rd(a_mb(0, 0), r); chk("R1 mode mb0", r, 0);
        rd(a_mb(3, 4), r); chk("R1 status mb3", r, 0);

        // R2 all disabled: frame dropped
        send(1'b0, 1'b0, 29'h55, 4'd2, 64'h1);
        chk("R2 all disabled", 32'(irq), 0);
        wr(a_mb(0, 0), 32'd3);
        send(1'b0, 1'b0, 29'h55, 4'd2, 64'h1);
        chk("R2 mode 3 disabled", 32'(irq), 0);
        wr(a_mb(0, 0), 32'd0);

        for (int m = 1; m < 7; m++) wr(a_mb(m, 0), 32'd1);
        wr(a_mb(7, 0), 32'd2);

        // R3/R6 fill in ascending order
        exp_irq = 0;
        for (int k = 0; k < 7; k++) begin
            send(1'b0, k == 3, 29'(32'h100 + k), 4'(k + 1),
                 {32'hC0DE0000 + 32'(k), 32'h12340000 + 32'(k * 3)});
            exp_irq[k + 1] = 1'b1;
            chk("R3 R6 fill order", 32'(irq), 32'(exp_irq));
        end
        // R5/R4 readback
        for (int k = 0; k < 7; k++) begin
            rd(a_mb(k + 1, 3), r); chk("R4 std key layout", r, (32'h100 + 32'(k)) << 18);
            rd(a_mb(k + 1, 4), r);
            chk("R5 status", r, (32'(k + 1) << 16) | (32'(k == 3) << 20) | (32'd1 << 23));
            rd(a_mb(k + 1, 5), r); chk("R5 data low", r, 32'h12340000 + 32'(k * 3));
            rd(a_mb(k + 1, 6), r); chk("R5 data high", r, 32'hC0DE0000 + 32'(k));
        end

        // R8 overwrite of full mode-2 mailbox
        send(1'b0, 1'b0, 29'h3AA, 4'd8, 64'hFEEDFACE_0BADF00D);
        chk("R8 irq after overwrite", 32'(irq), 32'hFE);
        rd(a_mb(7, 4), r); chk("R8 status missed", r, (32'd8 << 16) | (32'd1 << 23) | (32'd1 << 24));
        rd(a_mb(7, 5), r); chk("R8 data replaced", r, 32'h0BADF00D);
        rd(a_mb(7, 3), r); chk("R8 key replaced", r, 32'h3AA << 18);

        // R8/R2 plain full mailbox is not overwritten
        wr(a_mb(7, 0), 32'd1);
        send(1'b0, 1'b0, 29'h111, 4'd1, 64'h0);
        chk("R2 drop irq", 32'(irq), 32'hFE);
        rd(a_mb(7, 5), r); chk("R2 drop keeps data", r, 32'h0BADF00D);
        rd(a_mb(7, 3), r); chk("R8 plain keeps key", r, 32'h3AA << 18);
        rd(a_mb(1, 5), r); chk("R2 drop keeps mb1", r, 32'h12340000);
        chk("R9 reads keep full", 32'(irq), 32'hFE);

        // R7 re-arm groups
        wr(a_glb(1), 32'h07);
        chk("R7 rearm 0x07", 32'(irq), 32'hF8);
        wr(a_glb(1), 32'h80);
        chk("R7 rearm 0x80", 32'(irq), 32'h78);
        rd(a_mb(7, 4), r); chk("R7 missed cleared", r, 32'd8 << 16);
        rd(a_glb(0), r); chk("R7 full word", r, 32'h78);

        // R3 lowest free after re-arm
        send(1'b0, 1'b0, 29'h200, 4'd1, 64'h0);
        chk("R3 lowest free mb1", 32'(irq), 32'h7A);
        rd(a_mb(1, 3), r); chk("R3 mb1 key", r, 32'h200 << 18);
        send(1'b0, 1'b0, 29'h201, 4'd1, 64'h0);
        chk("R3 next free mb2", 32'(irq), 32'h7E);

        // R4 acceptance filters
        wr(a_glb(1), 32'hFF);
        chk("R7 rearm all", 32'(irq), 0);
        for (int m = 4; m < 8; m++) wr(a_mb(m, 0), 32'd0);
        wr(a_mb(1, 1), 32'h21234567); wr(a_mb(1, 2), 32'h1FFFFFFF);
        wr(a_mb(2, 1), 32'h123 << 18); wr(a_mb(2, 2), 32'h7FF << 18);
        wr(a_mb(3, 1), 32'h20000000); wr(a_mb(3, 2), 32'h0);
        send(1'b1, 1'b0, 29'h1234567, 4'd0, 64'h0);
        chk("R4 exact ext", 32'(irq), 32'h02);
        rd(a_mb(1, 3), r); chk("R4 ext key", r, 32'h21234567);
        send(1'b1, 1'b0, 29'h1234566, 4'd0, 64'h0);
        chk("R4 any ext", 32'(irq), 32'h0A);
        send(1'b0, 1'b0, 29'h123, 4'd0, 64'h0);
        chk("R4 exact std", 32'(irq), 32'h0E);
        send(1'b0, 1'b0, 29'h124, 4'd0, 64'h0);
        chk("R4 std mismatch", 32'(irq), 32'h0E);
        send(1'b1, 1'b0, 29'h1234567, 4'd0, 64'h0);
        chk("R2 no room", 32'(irq), 32'h0E);

        // R4 masked sweep on mailbox 4
        wr(a_glb(1), 32'hFF);
        for (int m = 1; m < 4; m++) wr(a_mb(m, 0), 32'd0);
        wr(a_mb(4, 0), 32'd1);
        wr(a_mb(4, 1), 32'h0F0 << 18);
        wr(a_mb(4, 2), 32'h7F0 << 18);
        for (int id = 'h0E0; id < 'h110; id++) begin
            send(1'b0, 1'b0, 29'(id), 4'd1, 64'h0);
            chk("R4 mask sweep", 32'(irq), ((id & 'h7F0) == 'h0F0) ? 32'h10 : 32'h0);
            wr(a_glb(1), 32'h10);
        end
        send(1'b1, 1'b0, 29'(32'h0F3 << 18), 4'd1, 64'h0);
        chk("R4 ext flag mismatch", 32'(irq), 0);

        finish_run();
    end
endmodule